// File: doc/BRIEF.md
# Microstepping Stepper Indexer

This block sequences the two winding currents of a bipolar stepper from a step/direction command pair. It keeps a position counter over one electrical cycle of 128 entries (about 2.8 degrees apart). Each rising edge of the step input moves the position forwards or backwards by an amount set by the chosen step resolution. For each winding the block turns the position into a sign bit and a 5-bit magnitude code, ready for a current DAC and an H-bridge driver. Winding A follows the cosine of the electrical angle and winding B follows the sine.

The step input may be asynchronous. It passes through a flop synchronizer and an edge detector, so a pulse of any length gives exactly one move. The resolution select and the direction input are taken at the moment the synchronized edge is seen, so the resolution can change while the motor turns. After such a change, the first move lands on the nearest position that is valid for the new resolution, rounded in the direction of travel. A per-winding flag reports that the last move raised the commanded magnitude. The decay logic downstream uses this flag to force slow decay. An output-disable input turns off the drive while the position keeps tracking the step input.

Top module: `stepper_indexer`

## Requirements
- R1: Each rising edge of `step_in` causes exactly one position move, however long `step_in` stays high. The new outputs appear within four clock cycles of the rising edge, and the position does not change without a step edge.
- R2: Resolution is picked by `res_hi` and the tri-level `res_lo` (00 = low, 01 = high, 1x = open). With res_hi=0: low is full step (32 entries per move), high is 1/2 (16), open is 1/4 (8). With res_hi=1: low is 1/8 (4), high is 1/16 (2), open is 1/32 (1).
- R3: With `dir`=1 the position increases by the move size, and with `dir`=0 it decreases. Both directions wrap modulo 128.
- R4: In full-step resolution the position only takes the values 16, 48, 80 and 112 (45, 135, 225 and 315 degrees). In every other resolution, the valid positions are the multiples of the move size.
- R5: When the current position is not valid for the resolution sampled at a step edge, the move goes to the nearest valid position above it (dir=1) or below it (dir=0), not a full move further.
- R6: Synchronous reset `rst` puts the position at 16 (45 degrees). Both magnitudes then read 22, both signs read positive, and both rising flags read 0.
- R7: At position p, `a_mag` = round(31*|cos(2*pi*p/128)|) and `b_mag` = round(31*|sin(2*pi*p/128)|). `a_neg` is 1 exactly when the cosine is below zero (p in 33..95). `b_neg` is 1 exactly when the sine is below zero (p in 65..127).
- R8: While `out_disable` is 1, `bridge_en`, both signs and both magnitudes read 0, yet step edges still move the position. After release, the outputs show the position that was reached.
- R9: `a_rising`/`b_rising` are 1 when the last move made that winding's magnitude strictly larger, and 0 otherwise. They hold their value until the next move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, returns to home |
| step_in | input | 1 | Step command, asynchronous, acts on rising edge |
| dir | input | 1 | Travel direction, 1 = increasing angle |
| res_hi | input | 1 | Resolution select, two-level signal |
| res_lo | input | 2 | Resolution select, tri-level: 00 low, 01 high, 1x open |
| out_disable | input | 1 | Forces the drive outputs off; position keeps tracking |
| bridge_en | output | 1 | Drive enable for both bridges |
| a_neg | output | 1 | Winding A current negative (output 2 above output 1) |
| a_mag | output | 5 | Winding A magnitude code, 0..31 for 0..100% |
| a_rising | output | 1 | Winding A magnitude rose on the last move |
| b_neg | output | 1 | Winding B current negative |
| b_mag | output | 5 | Winding B magnitude code |
| b_rising | output | 1 | Winding B magnitude rose on the last move |

## Verification
The bench uses the default two-stage synchronizer and the full 128-entry cycle. With these, all six resolutions, wrap-around through position 0 in both directions, and every table entry can be reached within a few hundred random steps. Random resolution changes in the middle of a move often leave the position misaligned, which exercises the rounding rule in both directions. Directed steps with a long step pulse and with the drive disabled check single-move behaviour and the tracking of position while the drive is off.

// File: rtl/stepper_pkg.sv
package stepper_pkg;
  localparam int IDX_W    = 7;
  localparam int MAG_W    = 5;
  localparam int N_POS    = 1 << IDX_W;
  localparam int QTR      = N_POS / 4;
  localparam int HALF     = N_POS / 2;
  localparam int HOME_IDX = QTR / 2;
  localparam int SHIFT_W  = 3;

  typedef enum logic [2:0] {
    RES_FULL = 3'd0,
    RES_HALF = 3'd1,
    RES_QTR  = 3'd2,
    RES_8TH  = 3'd3,
    RES_16TH = 3'd4,
    RES_32ND = 3'd5
  } res_t;

  // magnitude of the first quarter wave, 0..QTR inclusive
  function automatic logic [MAG_W-1:0] quarter_mag(input logic [5:0] k);
    logic [MAG_W-1:0] m;
    case (k)
      6'd0:  m = 5'd0;   6'd1:  m = 5'd2;   6'd2:  m = 5'd3;
      6'd3:  m = 5'd5;   6'd4:  m = 5'd6;   6'd5:  m = 5'd8;
      6'd6:  m = 5'd9;   6'd7:  m = 5'd10;  6'd8:  m = 5'd12;
      6'd9:  m = 5'd13;  6'd10: m = 5'd15;  6'd11: m = 5'd16;
      6'd12: m = 5'd17;  6'd13: m = 5'd18;  6'd14: m = 5'd20;
      6'd15: m = 5'd21;  6'd16: m = 5'd22;  6'd17: m = 5'd23;
      6'd18: m = 5'd24;  6'd19: m = 5'd25;  6'd20: m = 5'd26;
      6'd21: m = 5'd27;  6'd22: m = 5'd27;  6'd23: m = 5'd28;
      6'd24: m = 5'd29;  6'd25: m = 5'd29;  6'd26: m = 5'd30;
      6'd27: m = 5'd30;  6'd28: m = 5'd30;  6'd29: m = 5'd31;
      6'd30: m = 5'd31;  6'd31: m = 5'd31;  6'd32: m = 5'd31;
      default: m = 5'd0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/step_edge_sync.sv
module step_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_pulse
);
  logic [STAGES:0] chain_q;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign rise_pulse = chain_q[STAGES-1] & ~chain_q[STAGES];

  // R1: an edge yields a single-cycle pulse
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/res_decode.sv
module res_decode
  import stepper_pkg::*;
(
  input  logic               res_hi,
  input  logic [1:0]         res_lo,
  output res_t               res,
  output logic [SHIFT_W-1:0] move_shift
);
  always_comb begin
    if (!res_hi) begin
      if (res_lo[1])     res = RES_QTR;
      else if (res_lo[0]) res = RES_HALF;
      else               res = RES_FULL;
    end else begin
      if (res_lo[1])     res = RES_32ND;
      else if (res_lo[0]) res = RES_16TH;
      else               res = RES_8TH;
    end
  end

  always_comb begin
    case (res)
      RES_FULL: move_shift = 3'd5;
      RES_HALF: move_shift = 3'd4;
      RES_QTR:  move_shift = 3'd3;
      RES_8TH:  move_shift = 3'd2;
      RES_16TH: move_shift = 3'd1;
      default:  move_shift = 3'd0;
    endcase
  end
endmodule

// File: rtl/step_planner.sv
module step_planner
  import stepper_pkg::*;
(
  input  logic [IDX_W-1:0]   cur_idx,
  input  logic               dir,
  input  logic [SHIFT_W-1:0] move_shift,
  input  logic               full_mode,
  output logic [IDX_W-1:0]   nxt_idx
);
  logic [IDX_W-1:0] offset, rel, inc, mask, rel_nxt;
  logic             aligned;

  always_comb begin
    offset  = full_mode ? IDX_W'(HOME_IDX) : '0;
    inc     = IDX_W'(1) << move_shift;
    mask    = inc - IDX_W'(1);
    rel     = cur_idx - offset;
    aligned = ((rel & mask) == '0);
    if (dir) rel_nxt = aligned ? rel + inc : (rel | mask) + IDX_W'(1);
    else     rel_nxt = aligned ? rel - inc : (rel & ~mask);
    nxt_idx = rel_nxt + offset;
  end
endmodule

// File: rtl/wave_lut.sv
module wave_lut
  import stepper_pkg::*;
#(
  parameter int PHASE = 0
) (
  input  logic [IDX_W-1:0] idx,
  output logic             neg,
  output logic [MAG_W-1:0] mag
);
  logic [IDX_W-1:0] p;
  logic [IDX_W-2:0] k;
  logic [IDX_W-2:0] fold;

  always_comb begin
    p    = idx + IDX_W'(PHASE);
    k    = p[IDX_W-2:0];
    fold = (k > (IDX_W-1)'(QTR)) ? (IDX_W-1)'(HALF) - k : k;
    neg  = p[IDX_W-1] && (k != '0);
    mag  = quarter_mag(fold);
  end
endmodule

// File: rtl/stepper_indexer.sv
module stepper_indexer
  import stepper_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_in,
  input  logic             dir,
  input  logic             res_hi,
  input  logic [1:0]       res_lo,
  input  logic             out_disable,
  output logic             bridge_en,
  output logic             a_neg,
  output logic [MAG_W-1:0] a_mag,
  output logic             a_rising,
  output logic             b_neg,
  output logic [MAG_W-1:0] b_mag,
  output logic             b_rising
);
  localparam int N_WIND = 2;

  logic               step_pulse;
  res_t               res;
  logic [SHIFT_W-1:0] move_shift;
  logic [IDX_W-1:0]   idx_q, idx_nxt;
  logic [N_WIND-1:0]  cur_neg, nxt_neg, rise_q;
  logic [MAG_W-1:0]   cur_mag [N_WIND];
  logic [MAG_W-1:0]   nxt_mag [N_WIND];

  step_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(step_in), .rise_pulse(step_pulse)
  );

  res_decode u_dec (
    .res_hi(res_hi), .res_lo(res_lo), .res(res), .move_shift(move_shift)
  );

  step_planner u_plan (
    .cur_idx(idx_q), .dir(dir), .move_shift(move_shift),
    .full_mode(res == RES_FULL), .nxt_idx(idx_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)             idx_q <= IDX_W'(HOME_IDX);
    else if (step_pulse) idx_q <= idx_nxt;
  end

  genvar w;
  generate
    for (w = 0; w < N_WIND; w++) begin : g_wind
      // winding 0 (A) leads by a quarter cycle: cosine
      localparam int PH = (w == 0) ? QTR : 0;
      wave_lut #(.PHASE(PH)) u_cur (
        .idx(idx_q), .neg(cur_neg[w]), .mag(cur_mag[w])
      );
      wave_lut #(.PHASE(PH)) u_nxt (
        .idx(idx_nxt), .neg(nxt_neg[w]), .mag(nxt_mag[w])
      );
      always_ff @(posedge clk) begin
        if (rst)             rise_q[w] <= 1'b0;
        else if (step_pulse) rise_q[w] <= (nxt_mag[w] > cur_mag[w]);
      end
    end
  endgenerate

  assign bridge_en = ~out_disable;
  assign a_neg     = cur_neg[0] & ~out_disable;
  assign b_neg     = cur_neg[1] & ~out_disable;
  assign a_mag     = out_disable ? '0 : cur_mag[0];
  assign b_mag     = out_disable ? '0 : cur_mag[1];
  assign a_rising  = rise_q[0];
  assign b_rising  = rise_q[1];

  // R6: reset lands on home
  a_r6_home: assert property (@(posedge clk)
    rst |=> (idx_q == IDX_W'(HOME_IDX)));
  // R1: no move without a step edge
  a_r1_hold_still: assert property (@(posedge clk) disable iff (rst)
    !step_pulse |=> $stable(idx_q));
  // R4: full step lands on odd multiples of 45 degrees
  a_r4_full_grid: assert property (@(posedge clk) disable iff (rst)
    (step_pulse && res == RES_FULL) |=> (idx_q[4:0] == 5'd16));
  // R3: a 1/32 move changes the position by exactly one entry
  a_r3_fine_move: assert property (@(posedge clk) disable iff (rst)
    (step_pulse && res == RES_32ND) |=>
      (idx_q == ($past(dir) ? $past(idx_q) + 7'd1 : $past(idx_q) - 7'd1)));
  // R8: drive forced off while disabled
  a_r8_drive_off: assert property (@(posedge clk) disable iff (rst)
    out_disable |-> (!bridge_en && a_mag == '0 && b_mag == '0 && !a_neg && !b_neg));
  // R9: a rising flag implies a nonzero magnitude
  a_r9_rise_nonzero: assert property (@(posedge clk) disable iff (rst)
    (a_rising && !out_disable) |-> (a_mag != '0));
endmodule

// File: tb/stepper_indexer_test.sv
module stepper_indexer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_in = 1'b0, dir = 1'b1, res_hi = 1'b0, out_disable = 1'b0;
  logic [1:0] res_lo = 2'b00;
  logic bridge_en, a_neg, b_neg, a_rising, b_rising;
  logic [4:0] a_mag, b_mag;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int exp_idx = 16;
  int prev_a = 22, prev_b = 22;
  bit exp_ra = 0, exp_rb = 0;

  always #5 clk = ~clk;

  stepper_indexer uut (
    .clk(clk), .rst(rst), .step_in(step_in), .dir(dir), .res_hi(res_hi),
    .res_lo(res_lo), .out_disable(out_disable), .bridge_en(bridge_en),
    .a_neg(a_neg), .a_mag(a_mag), .a_rising(a_rising),
    .b_neg(b_neg), .b_mag(b_mag), .b_rising(b_rising)
  );

  function automatic real wave(input int p, input bit is_cos);
    real ang = 2.0 * 3.14159265358979 * p / 128.0;
    return is_cos ? $cos(ang) : $sin(ang);
  endfunction

  function automatic int mag_of(input int p, input bit is_cos);
    real v = wave(p, is_cos);
    if (v < 0.0) v = -v;
    return $rtoi(31.0 * v + 0.5);
  endfunction

  function automatic bit neg_of(input int p, input bit is_cos);
    return wave(p, is_cos) < -1.0e-6;
  endfunction

  function automatic int size_of(input bit hi, input logic [1:0] lo);
    int code = lo[1] ? 2 : (lo[0] ? 1 : 0);
    if (!hi) return (code == 0) ? 32 : (code == 1) ? 16 : 8;
    return (code == 0) ? 4 : (code == 1) ? 2 : 1;
  endfunction

  function automatic bit valid_pos(input int k, input int sz);
    if (sz == 32) return (k % 32) == 16;
    return (k % sz) == 0;
  endfunction

  function automatic int walk(input int from, input bit d, input int sz);
    int k = from;
    do k = d ? (k + 1) % 128 : (k + 127) % 128;
    while (!valid_pos(k, sz));
    return k;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (pos %0d)", req, act, exp, exp_idx);
    end
  endtask

  task automatic check_outputs(input string req);
    if (out_disable) begin
      check({req, " R8 en"}, bridge_en, 0);
      check({req, " R8 amag"}, a_mag, 0);
      check({req, " R8 bmag"}, b_mag, 0);
      check({req, " R8 sign"}, {a_neg, b_neg}, 0);
    end else begin
      check({req, " R8 en"}, bridge_en, 1);
      check({req, " R7 amag"}, a_mag, mag_of(exp_idx, 1));
      check({req, " R7 bmag"}, b_mag, mag_of(exp_idx, 0));
      check({req, " R7 aneg"}, a_neg, neg_of(exp_idx, 1));
      check({req, " R7 bneg"}, b_neg, neg_of(exp_idx, 0));
    end
    check({req, " R9 arise"}, a_rising, exp_ra);
    check({req, " R9 brise"}, b_rising, exp_rb);
  endtask

  task automatic do_step(input bit d, input bit hi, input logic [1:0] lo,
                         input int hold, input string req);
    int na, nb;
    @(negedge clk);
    dir = d; res_hi = hi; res_lo = lo;
    @(negedge clk);
    step_in = 1'b1;
    repeat (hold) @(negedge clk);
    step_in = 1'b0;
    repeat (4) @(negedge clk);
    exp_idx = walk(exp_idx, d, size_of(hi, lo));
    na = mag_of(exp_idx, 1);
    nb = mag_of(exp_idx, 0);
    exp_ra = na > prev_a;
    exp_rb = nb > prev_b;
    prev_a = na;
    prev_b = nb;
    check_outputs(req);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R6: reset state
    check("R6 amag", a_mag, 22);
    check("R6 bmag", b_mag, 22);
    check("R6 sign", {a_neg, b_neg}, 0);
    check("R6 rise", {a_rising, b_rising}, 0);
    check("R6 en", bridge_en, 1);

    // R4: full steps from home, both directions
    do_step(1, 0, 2'b00, 2, "R4 full up");
    check("R4 pos48", exp_idx, 48);
    do_step(0, 0, 2'b00, 2, "R4 full down");
    do_step(0, 0, 2'b00, 2, "R4 full wrap");
    check("R4 pos112", exp_idx, 112);
    // R1: long pulse gives a single move
    do_step(1, 0, 2'b01, 25, "R1 long pulse R2 half");
    check("R1 pos128wrap", exp_idx, 0);
    // R5: misalign with 1/32, then round in travel direction
    do_step(1, 1, 2'b10, 1, "R5 setup fine");
    do_step(1, 0, 2'b00, 2, "R5 round up full");
    check("R5 pos16", exp_idx, 16);
    do_step(0, 1, 2'b10, 1, "R5 setup fine down");
    do_step(0, 0, 2'b11, 2, "R5 round down quarter");
    check("R5 pos8", exp_idx, 8);
    // R8: disabled drive still tracks position
    out_disable = 1'b1;
    do_step(1, 1, 2'b00, 2, "R8 disabled step");
    do_step(1, 1, 2'b00, 2, "R8 disabled step2");
    @(negedge clk);
    out_disable = 1'b0;
    @(negedge clk);
    check_outputs("R8 after release");

    // R2 R3 R7 R9: random walk over resolutions and directions
    for (int i = 0; i < 400; i++) begin
      bit d = $urandom % 2;
      bit h = $urandom % 2;
      int c = $urandom % 3;
      logic [1:0] lo = (c == 2) ? ($urandom % 2 ? 2'b10 : 2'b11) : 2'(c);
      do_step(d, h, lo, 1 + ($urandom % 4), "R2 R3 random");
    end

    // R6: reset mid-cycle returns home
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    exp_idx = 16; exp_ra = 0; exp_rb = 0; prev_a = 22; prev_b = 22;
    check_outputs("R6 rereset");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule